// File: doc/BRIEF.md
# Serial EEPROM Boot Record Scanner

This block runs once after reset and fetches a start-up settings record from an optional serial EEPROM. A strap input is sampled in the first cycle after reset. When the strap is low, the block raises `done` and leaves the serial bus idle. When the strap is high, the block acts as an SPI master in mode 3. It first reads a short window at the bottom of the memory to decide whether the part holds programmed content. If the part looks programmed, it reads the record, removes an optional four-character ASCII header and forwards the remaining bytes on a valid/ready byte stream. It stops when it sees two carriage returns in a row.

Every read transaction has the same form. Chip select goes low, the master sends the read opcode and then a 16-bit start address, most significant byte first, and then clocks out bytes from consecutive addresses. Chip select goes high between passes and stays high for at least one SPI clock period.

The downstream consumer applies back-pressure through `out_ready`. While a byte waits in the output register, the SPI clock is held at its idle level, so no byte is read ahead and none is lost. If the address counter reaches its last location before the delimiter appears, the block stops and flags an error.

Top module: `cfg_boot_scan`

## Requirements
- R1: While reset is asserted, the block holds its idle state: chip select high, SPI clock high, `out_valid` low, and `done`, `absent` and `error` low.
- R2: If `strap_en` is low in the first cycle after reset, `done` rises with `absent` and `error` low. Chip select never falls and the SPI clock never toggles.
- R3: Every pass sends opcode 0x03 followed by start address 0x0000, most significant bit first. The SPI clock is high whenever chip select changes level. MOSI changes only while the SPI clock is low.
- R4: The probe pass reads from address 0 upward and stops at the first 0x0D byte. If none of the first PROBE_LEN (10) bytes is 0x0D, the block raises `absent` and `done`, reads exactly 10 data bytes, makes no further pass and forwards nothing.
- R5: A 0x0D byte at address 9, the last probe address, counts as a detected device.
- R6: If addresses 0 to 3 hold 0x42 0x4F 0x4F 0x54 ("BOOT"), those bytes are not forwarded. The payload starts at address 4 within the same read.
- R7: If any of the first four bytes differs from the header, a new pass starts at address 0 and every byte is forwarded, including any partial header prefix.
- R8: When two consecutive 0x0D bytes arrive, neither of them is forwarded. `done` rises, chip select returns high, and `done` then stays high. A single 0x0D followed by any other byte is forwarded as-is.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` stays stable and the SPI clock stays high. Every byte is delivered exactly once.
- R10: Between two passes, chip select stays high for at least 2*CLK_DIV system clock cycles.
- R11: If the byte at address MAX_ADDR has been read and no delimiter has been seen, `error` and `done` rise and `absent` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_en | input | 1 | Scan enable strap, sampled once after reset |
| spi_sck | output | 1 | SPI clock, idles high |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Master-to-memory serial data |
| spi_miso | input | 1 | Memory-to-master serial data |
| out_data | output | 8 | Forwarded record byte |
| out_valid | output | 1 | `out_data` holds a byte |
| out_ready | input | 1 | Consumer accepts the byte |
| done | output | 1 | Scan finished (sticky) |
| absent | output | 1 | No programmed device found |
| error | output | 1 | Address space ended before the delimiter |

## Verification
Each scenario uses its own memory image. Together they separate the different outcomes of the scan:
- A record that starts with "BOOT" tests that the header is stripped within a single pass.
- Plain text, and text starting with "BOX", test the rewind to address 0 and confirm that a partial header is forwarded.
- A window with no carriage return, and one whose only carriage return sits at address 9, pin down the edge of the probe window.
- A stream with only isolated carriage returns and no delimiter runs until the address limit and must set `error`.
- A run with intermittent `out_ready` checks that stalling the SPI clock loses no byte. In every run, the command words and chip-select gaps captured by the memory model confirm the framing on the wire.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam logic [7:0] CR_BYTE   = 8'h0D;
  localparam logic [7:0] RD_OPCODE = 8'h03;
  localparam logic [7:0] DUMMY_TX  = 8'hFF;

  typedef enum logic [1:0] {PASS_PROBE, PASS_HDR, PASS_BODY} pass_t;

  typedef enum logic [3:0] {
    ST_STRAP, ST_GAP, ST_SEND, ST_WAIT, ST_EVAL,
    ST_CRWAIT, ST_DRAIN, ST_NEXT, ST_END
  } state_t;

  // Expected header character at record offset idx ("BOOT")
  function automatic logic [7:0] hdr_char(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h42;
      2'd1:    return 8'h4F;
      2'd2:    return 8'h4F;
      default: return 8'h54;
    endcase
  endfunction
endpackage

// File: rtl/cbs_spi_byte.sv
// One-byte mode-3 shifter: SCK idles high, MOSI updates on the falling
// edge, MISO is captured on the rising edge.
module cbs_spi_byte #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_q;

  always_ff @(posedge clk) begin
    byte_done <= 1'b0;
    if (rst) begin
      sck     <= 1'b1;
      mosi    <= 1'b1;
      busy    <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      tx_q    <= '0;
      rx_byte <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      tx_q  <= tx_byte;
      div_q <= '0;
      bit_q <= '0;
    end else if (busy) begin
      if (div_q == DIV_W'(CLK_DIV - 1)) begin
        div_q <= '0;
        if (sck) begin
          sck  <= 1'b0;
          mosi <= tx_q[7];
        end else begin
          sck     <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
          tx_q    <= {tx_q[6:0], 1'b0};
          bit_q   <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            busy      <= 1'b0;
            byte_done <= 1'b1;
          end
        end
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/cbs_out_reg.sv
// Single registered output slot with valid/ready handshake.
module cbs_out_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else begin
      if (valid && ready) valid <= 1'b0;
      if (load) begin
        valid <= 1'b1;
        dout  <= din;
      end
    end
  end
endmodule

// File: rtl/cfg_boot_scan.sv
module cfg_boot_scan
  import cbs_pkg::*;
#(
  parameter int          CLK_DIV   = 4,
  parameter int          ADDR_W    = 16,
  parameter int unsigned MAX_ADDR  = 65535,
  parameter int          PROBE_LEN = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strap_en,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       done,
  output logic       absent,
  output logic       error
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int CMD_W      = $clog2(ADDR_BYTES + 2);
  localparam int GAP_CYC    = 2 * CLK_DIV;
  localparam int GAP_W      = $clog2(GAP_CYC + 1);
  localparam logic [CMD_W-1:0] CMD_DATA = CMD_W'(ADDR_BYTES + 1);

  state_t            state_q;
  pass_t             pass_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [GAP_W-1:0]  gap_q;
  logic [7:0]        cur_q;
  logic              cr_pend_q;

  logic       eng_start, eng_busy, eng_done;
  logic [7:0] eng_tx, eng_rx;
  logic       out_load;
  logic [7:0] out_din;

  cbs_spi_byte #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .start(eng_start), .tx_byte(eng_tx),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .busy(eng_busy),
    .byte_done(eng_done), .rx_byte(eng_rx)
  );

  cbs_out_reg #(.DATA_W(8)) u_out (
    .clk(clk), .rst(rst), .load(out_load), .din(out_din),
    .ready(out_ready), .valid(out_valid), .dout(out_data)
  );

  assign eng_start = (state_q == ST_SEND) && !eng_busy;

  always_comb begin
    if (cmd_q == '0)
      eng_tx = RD_OPCODE;
    else if (cmd_q < CMD_DATA)
      eng_tx = 8'(addr_q >> (8 * (ADDR_BYTES - int'(cmd_q))));
    else
      eng_tx = DUMMY_TX;
  end

  // A held CR is flushed ahead of the non-CR byte that follows it
  always_comb begin
    out_load = 1'b0;
    out_din  = cur_q;
    if (state_q == ST_EVAL && pass_q == PASS_BODY && cur_q != CR_BYTE) begin
      out_load = 1'b1;
      out_din  = cr_pend_q ? CR_BYTE : cur_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_STRAP;
      pass_q    <= PASS_PROBE;
      cmd_q     <= '0;
      addr_q    <= '0;
      gap_q     <= '0;
      cur_q     <= '0;
      cr_pend_q <= 1'b0;
      spi_cs_n  <= 1'b1;
      done      <= 1'b0;
      absent    <= 1'b0;
      error     <= 1'b0;
    end else begin
      case (state_q)
        ST_STRAP: begin
          gap_q <= '0;
          if (strap_en) state_q <= ST_GAP;
          else begin
            done    <= 1'b1;
            state_q <= ST_END;
          end
        end
        ST_GAP: begin
          spi_cs_n <= 1'b1;
          if (gap_q == GAP_W'(GAP_CYC - 1)) begin
            spi_cs_n  <= 1'b0;
            cmd_q     <= '0;
            addr_q    <= '0;
            cr_pend_q <= 1'b0;
            state_q   <= ST_SEND;
          end else begin
            gap_q <= gap_q + GAP_W'(1);
          end
        end
        ST_SEND: if (!eng_busy) state_q <= ST_WAIT;
        ST_WAIT: if (eng_done) begin
          if (cmd_q != CMD_DATA) begin
            cmd_q   <= cmd_q + CMD_W'(1);
            state_q <= ST_SEND;
          end else begin
            cur_q   <= eng_rx;
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          case (pass_q)
            PASS_PROBE: begin
              if (cur_q == CR_BYTE) begin
                spi_cs_n <= 1'b1;
                pass_q   <= PASS_HDR;
                gap_q    <= '0;
                state_q  <= ST_GAP;
              end else if (addr_q == ADDR_W'(PROBE_LEN - 1)) begin
                spi_cs_n <= 1'b1;
                absent   <= 1'b1;
                done     <= 1'b1;
                state_q  <= ST_END;
              end else begin
                addr_q  <= addr_q + ADDR_W'(1);
                state_q <= ST_SEND;
              end
            end
            PASS_HDR: begin
              if (cur_q != hdr_char(addr_q[1:0])) begin
                spi_cs_n <= 1'b1;
                pass_q   <= PASS_BODY;
                gap_q    <= '0;
                state_q  <= ST_GAP;
              end else begin
                if (addr_q[1:0] == 2'd3) pass_q <= PASS_BODY;
                state_q <= ST_NEXT;
              end
            end
            default: begin
              if (cur_q == CR_BYTE) begin
                if (cr_pend_q) begin
                  spi_cs_n <= 1'b1;
                  done     <= 1'b1;
                  state_q  <= ST_END;
                end else begin
                  cr_pend_q <= 1'b1;
                  state_q   <= ST_NEXT;
                end
              end else if (cr_pend_q) begin
                cr_pend_q <= 1'b0;
                state_q   <= ST_CRWAIT;
              end else begin
                state_q <= ST_DRAIN;
              end
            end
          endcase
        end
        ST_CRWAIT: if (!out_valid) state_q <= ST_EVAL;
        ST_DRAIN:  if (!out_valid) state_q <= ST_NEXT;
        ST_NEXT: begin
          if (addr_q == ADDR_W'(MAX_ADDR)) begin
            spi_cs_n <= 1'b1;
            error    <= 1'b1;
            done     <= 1'b1;
            state_q  <= ST_END;
          end else begin
            addr_q  <= addr_q + ADDR_W'(1);
            state_q <= ST_SEND;
          end
        end
        default: begin
          spi_cs_n <= 1'b1;
          state_q  <= ST_END;
        end
      endcase
    end
  end
endmodule

// File: rtl/cbs_boot_scan_chk.sv
module cbs_boot_scan_chk (
  input logic       clk,
  input logic       rst,
  input logic       spi_sck,
  input logic       spi_cs_n,
  input logic       spi_mosi,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       done,
  input logic       absent,
  input logic       error
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (spi_cs_n && spi_sck && !out_valid && !done && !absent && !error));

  p_cs_fall_idle_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> spi_sck);

  p_cs_rise_idle_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> spi_sck);

  p_mosi_low_phase_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_mosi) |-> !spi_sck);

  p_flag_absent_r4: assert property (@(posedge clk) disable iff (rst)
    absent |-> (done && !error));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (spi_cs_n && !out_valid));

  p_hold_data_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_sck_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> spi_sck);

  p_flag_error_r11: assert property (@(posedge clk) disable iff (rst)
    error |-> done);
endmodule

bind cfg_boot_scan cbs_boot_scan_chk u_cbs_chk (
  .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi), .out_data(out_data), .out_valid(out_valid),
  .out_ready(out_ready), .done(done), .absent(absent), .error(error)
);

// File: tb/cfg_boot_scan_bench.sv
module cfg_boot_scan_bench;
  localparam int CLK_DIV  = 2;
  localparam int MAX_ADDR = 63;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_en = 1'b0;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b1;
  logic [7:0] out_data;
  logic out_valid;
  logic out_ready = 1'b1;
  logic done, absent, error;

  always #2 clk = ~clk;

  cfg_boot_scan #(.CLK_DIV(CLK_DIV), .ADDR_W(16), .MAX_ADDR(MAX_ADDR), .PROBE_LEN(10)) u_cfg_boot_scan (
    .clk(clk), .rst(rst), .strap_en(strap_en), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .done(done), .absent(absent), .error(error)
  );

  int n_checks = 0;
  int n_errors = 0;

  logic [7:0]  mem [0:255];
  logic [7:0]  got [$];
  logic [23:0] cmd_log [$];

  // memory model and bus monitors, all sampled on the falling system edge
  logic        prev_sck = 1'b1, prev_cs = 1'b1, seen_rise = 1'b0, bp_mode = 1'b0;
  logic [23:0] s_cmd = '0;
  int s_bits = 0, last_bits = 0, cs_falls = 0, sck_toggles = 0;
  int high_cnt = 0, min_gap = 1000000, stall_err = 0, bp_cnt = 0;

  always @(negedge clk) begin
    if (rst) begin
      prev_sck = 1'b1; prev_cs = 1'b1; seen_rise = 1'b0; s_bits = 0;
      cs_falls = 0; sck_toggles = 0; high_cnt = 0; min_gap = 1000000;
      stall_err = 0; last_bits = 0;
    end else begin
      if (spi_sck != prev_sck) sck_toggles++;
      if (!spi_cs_n && prev_cs) begin
        cs_falls++;
        if (seen_rise && high_cnt < min_gap) min_gap = high_cnt;
        s_bits = 0;
      end
      if (spi_cs_n && !prev_cs) begin
        last_bits = s_bits;
        seen_rise = 1'b1;
      end
      high_cnt = spi_cs_n ? high_cnt + 1 : 0;
      if (!spi_cs_n) begin
        if (spi_sck && !prev_sck) begin
          if (s_bits < 24) s_cmd = {s_cmd[22:0], spi_mosi};
          s_bits++;
          if (s_bits == 24) cmd_log.push_back(s_cmd);
        end
        if (!spi_sck && prev_sck && s_bits >= 24) begin
          automatic int d = s_bits - 24;
          automatic logic [15:0] a = s_cmd[15:0] + 16'(d / 8);
          spi_miso = mem[a[7:0]][7 - (d % 8)];
        end
      end
      if (out_valid && !out_ready && !spi_sck) stall_err++;
      prev_sck = spi_sck;
      prev_cs  = spi_cs_n;
    end
    // ready for the coming edge is set first, then the handshake is recorded
    bp_cnt++;
    out_ready = bp_mode ? ((bp_cnt % 7) < 2) : 1'b1;
    if (!rst && out_valid && out_ready) got.push_back(out_data);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_image(input string s);
    for (int i = 0; i < 256; i++) mem[i] = 8'h41;
    for (int i = 0; i < s.len(); i++) mem[i] = s[i];
  endtask

  task automatic start_scan(input bit strap, input bit bp);
    @(negedge clk);
    rst = 1'b1; strap_en = strap; bp_mode = bp;
    got.delete(); cmd_log.delete();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 30000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, req, done, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_stream(input string exp, input string req);
    check(got.size() == exp.len(), req, got.size(), exp.len());
    for (int i = 0; i < exp.len() && i < got.size(); i++)
      check(got[i] == exp[i], req, got[i], exp[i]);
  endtask

  task automatic expect_cmds(input int passes, input string req);
    check(cs_falls == passes, req, cs_falls, passes);
    check(cmd_log.size() == passes, req, cmd_log.size(), passes);
    foreach (cmd_log[i]) check(cmd_log[i] == 24'h030000, req, cmd_log[i], 24'h030000);
  endtask

  // R1, R2
  task automatic t_reset_and_strap_off();
    load_image("BOOTX\r\r");
    @(negedge clk);
    rst = 1'b1; strap_en = 1'b0;
    repeat (3) @(negedge clk);
    check(spi_cs_n && spi_sck && !out_valid && !done && !absent && !error, "R1 reset state",
          {spi_cs_n, spi_sck, out_valid, done, absent, error}, 6'b110000);
    rst = 1'b0;
    repeat (200) @(negedge clk);
    check(done == 1'b1, "R2 done with strap low", done, 1);
    check(!absent && !error, "R2 flags", {absent, error}, 0);
    check(cs_falls == 0, "R2 no chip select", cs_falls, 0);
    check(sck_toggles == 0, "R2 no clock", sck_toggles, 0);
    check(got.size() == 0, "R2 no output", got.size(), 0);
  endtask

  // R6, R3, R8, R10
  task automatic t_header();
    load_image("BOOTAT1\rAT2\r\r");
    start_scan(1'b1, 1'b0);
    wait_done("R8 done after delimiter");
    expect_stream("AT1\rAT2", "R6 header stripped");
    expect_cmds(2, "R3 command framing");
    check(min_gap >= 2 * CLK_DIV, "R10 chip select gap", min_gap, 2 * CLK_DIV);
    check(!absent && !error && spi_cs_n, "R8 clean finish", {absent, error, spi_cs_n}, 1);
  endtask

  // R7
  task automatic t_plain();
    load_image("AT\rX\r\r");
    start_scan(1'b1, 1'b0);
    wait_done("R7 done");
    expect_stream("AT\rX", "R7 plain record");
    expect_cmds(3, "R7 rewind pass");
    load_image("BOX\r\r");
    start_scan(1'b1, 1'b0);
    wait_done("R7 done partial");
    expect_stream("BOX", "R7 partial header forwarded");
    expect_cmds(3, "R7 rewind partial");
  endtask

  // R4
  task automatic t_absent();
    load_image("AAAAAAAAAA\r\r");
    start_scan(1'b1, 1'b0);
    wait_done("R4 done");
    check(absent == 1'b1 && error == 1'b0, "R4 absent flag", {absent, error}, 2);
    expect_cmds(1, "R4 single pass");
    check(last_bits == 24 + 80, "R4 ten bytes read", last_bits, 104);
    check(got.size() == 0, "R4 nothing forwarded", got.size(), 0);
  endtask

  // R5
  task automatic t_probe_edge();
    load_image("ABCDEFGHI\r\r");
    start_scan(1'b1, 1'b0);
    wait_done("R5 done");
    check(absent == 1'b0, "R5 detected at address 9", absent, 0);
    expect_stream("ABCDEFGHI", "R5 record");
  endtask

  // R9
  task automatic t_backpressure();
    load_image("BOOTL1\rL2\rL3\r\r");
    start_scan(1'b1, 1'b1);
    wait_done("R9 done");
    expect_stream("L1\rL2\rL3", "R9 no byte lost");
    check(stall_err == 0, "R9 clock stalled", stall_err, 0);
    bp_mode = 1'b0;
  endtask

  // R11
  task automatic t_overflow();
    load_image("\r");
    start_scan(1'b1, 1'b0);
    wait_done("R11 done");
    check(error == 1'b1 && absent == 1'b0, "R11 error flag", {error, absent}, 2);
    check(got.size() == MAX_ADDR + 1, "R11 bytes before limit", got.size(), MAX_ADDR + 1);
    if (got.size() > 0) check(got[0] == 8'h0D, "R11 single CR forwarded", got[0], 13);
  endtask

  initial begin
    fork
      begin
        t_reset_and_strap_off();
        t_header();
        t_plain();
        t_absent();
        t_probe_edge();
        t_backpressure();
        t_overflow();
      end
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule